// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block keeps a small, fully associative set of recent page-to-frame translations in front of a page-table walker. A lookup gives a logical address and the identifier of the running process. In the same cycle the block compares the page number, which is every bit above the offset, and the process identifier against every stored entry. On a hit it returns the physical address, formed from the stored frame number with the untouched offset below it. On a miss it raises a flag so that the walker can fetch the translation. The walker then hands the finished translation back through the refill port.

Each entry carries the identifier of the process that owns it. For that reason a context switch needs no flush, and translations of several processes can be held together. A full flush is still provided, together with a command that drops only the entries of one process. New translations go first into the lowest-numbered free slot. When the cache is full, a rotating pointer picks the slot to overwrite. A refill for a page and process already held rewrites that entry in place.

Top module: `tlb_tagged`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup whose page number and process identifier equal those of a valid entry raises `lk_hit` in the same cycle, and `lk_paddr` then holds that entry's frame number above the offset.
- R3: Only bits [VA_W-1:OFF_W] of `lk_vaddr` take part in the match. The low OFF_W bits are copied unchanged into the low OFF_W bits of `lk_paddr`.
- R4: A lookup whose page number matches an entry owned by another process misses. Two processes can hold the same page number with different frames.
- R5: A refill becomes visible from the cycle after it is presented. A lookup for the same page in the refill cycle itself misses.
- R6: A refill for a page and process already held overwrites that entry's frame and uses no free slot, so no two valid entries share a tag.
- R7: A refill for a new tag goes to the lowest-numbered invalid entry. When all entries are valid, it goes to the entry under a rotating pointer, which starts at 0 after reset and advances by one, wrapping, after each such eviction.
- R8: `flush_all` invalidates every entry from the next cycle. A refill presented in the same cycle is discarded.
- R9: `inv_valid` invalidates, from the next cycle, exactly the entries whose process identifier equals `inv_pid`. A refill in the same cycle is applied after the invalidation and survives.
- R10: `lk_hit` and `lk_miss` are never high together. Both are low and `lk_paddr` is zero when `lk_valid` is low, and `lk_paddr` is zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Logical address to translate |
| lk_pid | input | PID_W | Process identifier of the lookup |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found none; walk needed |
| lk_paddr | output | PFN_W+OFF_W | Translated physical address |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VA_W-OFF_W | Page number of the refill |
| fill_pid | input | PID_W | Process identifier of the refill |
| fill_pfn | input | PFN_W | Frame number of the refill |
| flush_all | input | 1 | Invalidate every entry |
| inv_valid | input | 1 | Invalidate entries of one process |
| inv_pid | input | PID_W | Process whose entries are dropped |

## Verification
The bench fills all sixteen slots and then evicts past the end. A design that used the rotating pointer while free slots remained, or that started it anywhere but slot 0, would lose the wrong page, and a later sweep over known tags would catch the extra or missing hit. It re-presents a tag that is already held with a new frame. A design that allocated a second slot would report the old frame or run out of room one refill early. It also presents a refill at the same time as a flush, as a per-process invalidate, and as a lookup of the same page. A design that ordered these wrongly would keep a discarded refill, lose a refill that should survive, or hit one cycle too early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Where a refill lands
  typedef enum logic [1:0] {
    VIC_SAME = 2'd0,   // tag already present: rewrite it
    VIC_FREE = 2'd1,   // lowest invalid slot
    VIC_RR   = 2'd2    // all slots full: rotating pointer
  } vic_src_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [N-1:0][PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [PID_W-1:0]        key_pid,
  output logic [N-1:0]            match_vec,
  output logic                    any_hit,
  output logic [IDX_W-1:0]        hit_idx
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i[IDX_W-1:0];
    return r;
  endfunction

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign match_vec[gi] = ent_valid[gi] && (ent_vpn[gi] == key_vpn) && (ent_pid[gi] == key_pid);
  end

  assign any_hit = |match_vec;
  assign hit_idx = lowest_set(match_vec);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_valid,
  input  logic             same_hit,
  input  logic [IDX_W-1:0] same_idx,
  input  logic             fill_go,
  output logic [IDX_W-1:0] vic_idx,
  output vic_src_t         vic_src
);
  logic [IDX_W-1:0] rr_q;
  logic [N-1:0]     free_vec;

  function automatic logic [IDX_W-1:0] first_free(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i[IDX_W-1:0];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] rr_step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign free_vec = ~ent_valid;

  always_comb begin
    if (same_hit) begin
      vic_src = VIC_SAME;
      vic_idx = same_idx;
    end else if (|free_vec) begin
      vic_src = VIC_FREE;
      vic_idx = first_free(free_vec);
    end else begin
      vic_src = VIC_RR;
      vic_idx = rr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (fill_go && vic_src == VIC_RR) rr_q <= rr_step(rr_q);
  end

  // R7
  rr_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && vic_src == VIC_RR) |-> (&ent_valid));
  // R7
  free_slot_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && vic_src == VIC_FREE) |-> !ent_valid[vic_idx]);
  // R7
  rr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && vic_src == VIC_RR) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int PID_W = 8,
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PFN_W + OFF_W,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             flush_all,
  input  logic             inv_valid,
  input  logic [PID_W-1:0] inv_pid
);
  logic [N_ENT-1:0]            valid_q;
  logic [N_ENT-1:0][VPN_W-1:0] vpn_q;
  logic [N_ENT-1:0][PID_W-1:0] pid_q;
  logic [N_ENT-1:0][PFN_W-1:0] pfn_q;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] a);
    return a[VA_W-1:OFF_W];
  endfunction
  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // Named internal events
  logic [N_ENT-1:0] lk_match_vec, fill_match_vec;
  logic             lk_any, fill_same;
  logic [IDX_W-1:0] lk_idx, fill_same_idx, vic_idx;
  vic_src_t         vic_src;
  logic             fill_go;

  assign fill_go = fill_valid && !flush_all;

  tlb_match #(.N(N_ENT), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_pid(pid_q),
    .key_vpn(page_of(lk_vaddr)), .key_pid(lk_pid),
    .match_vec(lk_match_vec), .any_hit(lk_any), .hit_idx(lk_idx));

  tlb_match #(.N(N_ENT), .VPN_W(VPN_W), .PID_W(PID_W)) u_fill_match (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_pid(pid_q),
    .key_vpn(fill_vpn), .key_pid(fill_pid),
    .match_vec(fill_match_vec), .any_hit(fill_same), .hit_idx(fill_same_idx));

  tlb_victim #(.N(N_ENT)) u_victim (
    .clk(clk), .rst_n(rst_n), .ent_valid(valid_q),
    .same_hit(fill_same), .same_idx(fill_same_idx), .fill_go(fill_go),
    .vic_idx(vic_idx), .vic_src(vic_src));

  assign lk_hit   = lk_valid && lk_any;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_paddr = lk_hit ? {pfn_q[lk_idx], offset_of(lk_vaddr)} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      pfn_q   <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++)
        if (inv_valid && pid_q[i] == inv_pid) valid_q[i] <= 1'b0;
      if (fill_valid) begin
        valid_q[vic_idx] <= 1'b1;
        vpn_q[vic_idx]   <= fill_vpn;
        pid_q[vic_idx]   <= fill_pid;
        pfn_q[vic_idx]   <= fill_pfn;
      end
    end
  end

  // R10
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss) && (lk_valid == (lk_hit || lk_miss)));
  // R6
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec) && $onehot0(fill_match_vec));
  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));
  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (!(lk_valid && page_of(lk_vaddr) == $past(fill_vpn) && lk_pid == $past(fill_pid))
                 || (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_pfn))));
  // R9
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid && !flush_all) |=> !(lk_hit && lk_pid == $past(inv_pid)));
endmodule

// File: tb/test_tlb_tagged.sv
module test_tlb_tagged;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid, lk_hit, lk_miss, fill_valid, flush_all, inv_valid;
  logic [31:0] lk_vaddr, lk_paddr;
  logic [7:0]  lk_pid, fill_pid, inv_pid;
  logic [19:0] fill_vpn, fill_pfn;

  always #5 clk = ~clk;

  tlb_tagged i_tlb_tagged (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
    .flush_all(flush_all), .inv_valid(inv_valid), .inv_pid(inv_pid));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference table, restated from the requirements
  bit        m_v [16];
  bit [19:0] m_vpn [16];
  bit [7:0]  m_pid [16];
  bit [19:0] m_pfn [16];
  int        m_rr = 0;

  // scoreboard queues
  bit          q_lk [$];
  bit          q_hit [$];
  logic [31:0] q_pa [$];
  string       q_req [$];

  bit [19:0] sw_vpn [22];
  bit [7:0]  sw_pid [22];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit lkv, input logic [31:0] va, input logic [7:0] lpid,
                     input bit fv, input logic [19:0] fvpn, input logic [7:0] fpid,
                     input logic [19:0] fpfn, input bit fl, input bit iv,
                     input logic [7:0] ipid, input string req);
    bit eh;
    logic [31:0] epa;
    int same, free;
    @(posedge clk);
    #1;
    lk_valid = lkv; lk_vaddr = va; lk_pid = lpid;
    fill_valid = fv; fill_vpn = fvpn; fill_pid = fpid; fill_pfn = fpfn;
    flush_all = fl; inv_valid = iv; inv_pid = ipid;
    eh = 0; epa = '0;
    for (int i = 0; i < 16; i++)
      if (lkv && m_v[i] && m_vpn[i] == va[31:12] && m_pid[i] == lpid) begin
        eh = 1; epa = {m_pfn[i], va[11:0]};
      end
    q_lk.push_back(lkv); q_hit.push_back(eh); q_pa.push_back(epa); q_req.push_back(req);
    // next state of the table
    if (fl) begin
      for (int i = 0; i < 16; i++) m_v[i] = 0;
    end else begin
      same = -1; free = -1;
      for (int i = 15; i >= 0; i--) begin
        if (m_v[i] && m_vpn[i] == fvpn && m_pid[i] == fpid) same = i;
        if (!m_v[i]) free = i;
      end
      if (iv) for (int i = 0; i < 16; i++) if (m_pid[i] == ipid) m_v[i] = 0;
      if (fv) begin
        if (same < 0) begin
          if (free >= 0) same = free;
          else begin same = m_rr; m_rr = (m_rr + 1) % 16; end
        end
        m_v[same] = 1; m_vpn[same] = fvpn; m_pid[same] = fpid; m_pfn[same] = fpfn;
      end
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] p, input string req);
    cyc(1, va, p, 0, '0, '0, '0, 0, 0, '0, req);
  endtask
  task automatic fill(input logic [19:0] vpn, input logic [7:0] p, input logic [19:0] pfn, input string req);
    cyc(0, '0, '0, 1, vpn, p, pfn, 0, 0, '0, req);
  endtask
  task automatic idle(input string req);
    cyc(0, '0, '0, 0, '0, '0, '0, 0, 0, '0, req);
  endtask
  task automatic sweep(input string req);
    for (int k = 0; k < 22; k++) look({sw_vpn[k], 12'(k * 37 + 5)}, sw_pid[k], req);
  endtask

  // monitor: pops one expectation per cycle
  always @(negedge clk) begin
    if (q_lk.size() > 0) begin
      bit v, h;
      logic [31:0] pa;
      string r;
      v = q_lk.pop_front(); h = q_hit.pop_front(); pa = q_pa.pop_front(); r = q_req.pop_front();
      if (v) begin
        chk(lk_hit == h && lk_miss == !h, r, "hit", {31'd0, lk_hit}, {31'd0, h});
        chk(lk_paddr == pa, r, "paddr", lk_paddr, pa);
      end else begin
        chk(!lk_hit && !lk_miss && lk_paddr == '0, "R10", "idle outputs", {lk_hit, lk_miss, lk_paddr[29:0]}, '0);
      end
    end
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    sw_vpn[0] = 20'h12345; sw_pid[0] = 8'd3;
    sw_vpn[1] = 20'h12345; sw_pid[1] = 8'd4;
    for (int k = 0; k < 14; k++) begin sw_vpn[2 + k] = 20'h00100 + 20'(k); sw_pid[2 + k] = 8'd5; end
    sw_vpn[16] = 20'h00200; sw_pid[16] = 8'd5;
    sw_vpn[17] = 20'h00201; sw_pid[17] = 8'd5;
    sw_vpn[18] = 20'h00300; sw_pid[18] = 8'd5;
    sw_vpn[19] = 20'h00400; sw_pid[19] = 8'd6;
    sw_vpn[20] = 20'h00401; sw_pid[20] = 8'd6;
    sw_vpn[21] = 20'h12345; sw_pid[21] = 8'd5;
    lk_valid = 0; lk_vaddr = '0; lk_pid = '0; fill_valid = 0; fill_vpn = '0; fill_pid = '0;
    fill_pfn = '0; flush_all = 0; inv_valid = 0; inv_pid = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: nothing valid after reset
    sweep("R1");
    // R5: lookup in the refill cycle misses, next cycle hits
    cyc(1, 32'h12345_7FF, 8'd3, 1, 20'h12345, 8'd3, 20'hABCDE, 0, 0, '0, "R5");
    look(32'h12345_7FF, 8'd3, "R2");
    // R3: offset is passed through and ignored by the match
    look(32'h12345_000, 8'd3, "R3");
    look(32'h12345_FFF, 8'd3, "R3");
    // R4: other process misses, then holds its own frame
    look(32'h12345_123, 8'd4, "R4");
    fill(20'h12345, 8'd4, 20'h11111, "R4");
    look(32'h12345_456, 8'd3, "R4");
    look(32'h12345_456, 8'd4, "R4");
    // R6: refill of a held tag rewrites in place
    fill(20'h12345, 8'd3, 20'h22222, "R6");
    look(32'h12345_abc, 8'd3, "R6");
    // R7: fill to full, then evict by rotation
    for (int k = 0; k < 14; k++) fill(20'h00100 + 20'(k), 8'd5, 20'h50000 + 20'(k), "R7");
    sweep("R7");
    fill(20'h00200, 8'd5, 20'h60000, "R7");
    sweep("R7");
    fill(20'h00201, 8'd5, 20'h60001, "R7");
    sweep("R7");
    // R9: invalidate with a same-cycle refill of that process
    cyc(0, '0, '0, 1, 20'h00300, 8'd5, 20'h70000, 0, 1, 8'd5, "R9");
    sweep("R9");
    fill(20'h00400, 8'd6, 20'h80000, "R9");
    fill(20'h00401, 8'd6, 20'h80001, "R9");
    cyc(0, '0, '0, 0, '0, '0, '0, 0, 1, 8'd7, "R9");
    sweep("R9");
    cyc(0, '0, '0, 0, '0, '0, '0, 0, 1, 8'd5, "R9");
    sweep("R9");
    // R8: flush drops everything, including a same-cycle refill
    cyc(1, 32'h00400_010, 8'd6, 1, 20'h12345, 8'd5, 20'h90000, 1, 0, '0, "R8");
    sweep("R8");
    fill(20'h00777, 8'd9, 20'hCAFE0, "R8");
    look(32'h00777_321, 8'd9, "R8");
    // R10: idle cycles
    idle("R10");
    idle("R10");
    @(posedge clk);
    #1 lk_valid = 0; fill_valid = 0; flush_all = 0; inv_valid = 0;
    while (q_lk.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule